// File: doc/BRIEF.md
# Serial Flash Command Phase Sequencer

This block emits the command portion of a serial flash transaction: an optional 8-bit opcode phase followed by an optional address phase of 8, 16, 24 or 32 bits. Each of the two phases has its own bus width of one, two or four data lines, or is skipped entirely. The block generates the serial clock at half the system clock rate, frames the command with an active-low chip select, and drives four data lines with per-line output enables.

Configuration (opcode, the two phase line modes, address size) is written through a write strobe and is frozen while a command is running. The address has its own write strobe, and that strobe is ignored while a command runs or while the memory-mapped mode input is high. When the dual-device flag is set, the least significant address bit goes out as 0. A one-cycle start pulse while idle launches a command. Busy rises on the next clock and stays high until one cycle after chip select goes high again.

Top module: `qspi_cmd_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, dq_oe is 4'b0000 and busy is 0.
- R2: The opcode line mode code selects 00 = no opcode phase, 01 = one line (dq[0]), 10 = two lines (dq[1:0]), 11 = four lines (dq[3:0]). The opcode phase sends 8 bits, so it takes 8, 4 or 2 serial clocks.
- R3: The address line mode code uses the same encoding as R2 and applies only to the address phase, which follows the opcode phase.
- R4: The address size code selects how many low address bits are sent: 00 = 8, 01 = 16, 10 = 24, 11 = 32.
- R5: Bits go out most significant first. In a multi-line beat, the higher-numbered line carries the more significant bit.
- R6: Writes through cfg_we while busy is 1 have no effect. The next command uses the previously written settings.
- R7: Writes through addr_we while mmap_mode is 1, or while busy is 1, leave the stored address unchanged.
- R8: When dual_flash is 1 at start, address bit 0 is transmitted as 0.
- R9: A start pulse while busy is 0 raises busy on the next clock. Busy falls one clock after cs_n returns high. A start pulse while busy is 1 is ignored.
- R10: sclk is 0 whenever cs_n is 1. cs_n falls two clocks after busy rises, stays low for exactly two clocks per serial beat, and data changes only while sclk goes low.
- R11: dq_oe has bits set only for the lines used by the current phase, and is 4'b0000 whenever cs_n is 1.
- R12: With both line mode codes at 00, a start pulse makes busy high for exactly one clock, and cs_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for opcode and mode settings |
| cfg_opcode | input | 8 | Opcode byte to send |
| cfg_op_lines | input | 2 | Opcode phase line mode code |
| cfg_ad_lines | input | 2 | Address phase line mode code |
| cfg_ad_size | input | 2 | Address size code |
| addr_we | input | 1 | Write strobe for the address value |
| addr_val | input | 32 | Address value |
| dual_flash | input | 1 | Force transmitted address even |
| mmap_mode | input | 1 | Memory-mapped mode indication; blocks address writes |
| start | input | 1 | Launch a command when idle |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| dq_out | output | 4 | Data line drive values |
| dq_oe | output | 4 | Per-line output enables |
| busy | output | 1 | Command in progress |

## Verification
A corrupted beat counter shows up at the ports as a chip select window of the wrong length, visible the clock cs_n would have risen. A wrong shift or lane mapping corrupts the first serial beat that uses it, so the stream comparison catches it within two clocks. A lock that leaks is invisible during the current command but shows up in the very next command's opcode or address bits, so every locking test is followed by a transfer compared against the unchanged settings. A state machine that fails to return to idle keeps busy high, and the bench's busy length check reports it.

// File: rtl/qcs_pkg.sv
// Package: shared types and helpers for the command phase sequencer.
// Assumes a four-line serial bus and line mode codes 00/01/10/11.
package qcs_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        LM_NONE = 2'b00,
        LM_ONE  = 2'b01,
        LM_TWO  = 2'b10,
        LM_FOUR = 2'b11
    } line_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EMPTY,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        line_mode_e op_lines;
        line_mode_e ad_lines;
        logic [1:0] ad_size;
    } cmd_cfg_t;

    // Number of data lines a mode drives per beat.
    function automatic logic [2:0] lanes_of(line_mode_e m);
        case (m)
            LM_ONE:  return 3'd1;
            LM_TWO:  return 3'd2;
            LM_FOUR: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // log2 of the line count, used to turn a bit count into a beat count.
    function automatic logic [1:0] lanes_log2(line_mode_e m);
        case (m)
            LM_TWO:  return 2'd1;
            LM_FOUR: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/qcs_cfg_bank.sv
// Module: holds the command settings and the address value.
// Settings are written only while the sequencer is idle. Address writes
// are also dropped while memory-mapped mode is indicated.
module qcs_cfg_bank
    import qcs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              mmap_mode,
    input  logic              cfg_we,
    input  cmd_cfg_t          cfg_in,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    output cmd_cfg_t          cfg_q,
    output logic [ADDR_W-1:0] addr_q
);

    // Settings register, writable only when no command is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we && !busy) begin
            cfg_q <= cfg_in;
        end
    end

    // Address register, blocked while busy or in memory-mapped mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_we && !busy && !mmap_mode) begin
            addr_q <= addr_in;
        end
    end

    a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q));

    a_r7_addr_locked_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));

    a_r7_addr_locked_mmap: assert property (@(posedge clk) disable iff (!rst_n)
        mmap_mode |=> $stable(addr_q));

endmodule

// File: rtl/qcs_lane_map.sv
// Module: maps the top four bits of a shift register onto the data lines
// for a given line mode. The more significant bit lands on the higher line,
// and only the lines in use get an enable.
module qcs_lane_map
    import qcs_pkg::*;
(
    input  line_mode_e        mode,
    input  logic [LANES-1:0]  top_bits,
    output logic [LANES-1:0]  dq,
    output logic [LANES-1:0]  oe
);

    // Lane selection by mode.
    always_comb begin
        case (mode)
            LM_ONE: begin
                dq = {3'b000, top_bits[3]};
                oe = 4'b0001;
            end
            LM_TWO: begin
                dq = {2'b00, top_bits[3:2]};
                oe = 4'b0011;
            end
            LM_FOUR: begin
                dq = top_bits;
                oe = 4'b1111;
            end
            default: begin
                dq = '0;
                oe = '0;
            end
        endcase
    end

endmodule

// File: rtl/qcs_seq.sv
// Module: command sequencer. On start it latches the settings, waits one
// serial clock period with chip select high, then shifts out the opcode
// and address beats, one beat per two system clocks (low half, high half).
// Data changes as sclk goes low. Assumes settings are held by qcs_cfg_bank.
module qcs_seq
    import qcs_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INSTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dual_flash,
    input  cmd_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              sclk,
    output logic              cs_n,
    output logic [LANES-1:0]  dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              busy
);

    localparam int INS_CNT_W = $clog2(INSTR_W + 1);
    localparam int ADR_CNT_W = $clog2(ADDR_W + 1);
    localparam int SIZE_STEP = ADDR_W / 4;

    seq_state_e             state;
    logic                   lead_done;
    line_mode_e             op_mode_l;
    line_mode_e             ad_mode_l;
    logic [INSTR_W-1:0]     ins_sh;
    logic [ADDR_W-1:0]      adr_sh;
    logic [INS_CNT_W-1:0]   ins_left;
    logic [ADR_CNT_W-1:0]   adr_left;

    logic                   use_ins;
    line_mode_e             src_mode;
    logic [LANES-1:0]       src_top;
    logic [LANES-1:0]       emit_dq;
    logic [LANES-1:0]       emit_oe;
    logic                   beats_left;

    logic [ADR_CNT_W-1:0]   ad_bits;
    logic [ADDR_W-1:0]      ad_masked;
    logic [ADDR_W-1:0]      ad_aligned;
    logic [INS_CNT_W-1:0]   ins_beats;
    logic [ADR_CNT_W-1:0]   adr_beats;

    // Load values for a new command: beat counts and left-aligned address.
    always_comb begin
        ad_bits    = ADR_CNT_W'((32'(cfg.ad_size) + 32'd1) * SIZE_STEP);
        ad_masked  = dual_flash ? {addr[ADDR_W-1:1], 1'b0} : addr;
        ad_aligned = ad_masked << (ADDR_W - int'(ad_bits));
        ins_beats  = (cfg.op_lines == LM_NONE) ? '0
                   : INS_CNT_W'(INSTR_W >> lanes_log2(cfg.op_lines));
        adr_beats  = (cfg.ad_lines == LM_NONE) ? '0
                   : ad_bits >> lanes_log2(cfg.ad_lines);
    end

    // Source selection for the next beat: opcode bits first, then address.
    always_comb begin
        use_ins    = (ins_left != '0);
        src_mode   = use_ins ? op_mode_l : ad_mode_l;
        src_top    = use_ins ? ins_sh[INSTR_W-1 -: LANES] : adr_sh[ADDR_W-1 -: LANES];
        beats_left = (ins_left != '0) || (adr_left != '0);
    end

    qcs_lane_map u_map (
        .mode     (src_mode),
        .top_bits (src_top),
        .dq       (emit_dq),
        .oe       (emit_oe)
    );

    // Main state machine with serial clock, framing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lead_done <= 1'b0;
            op_mode_l <= LM_NONE;
            ad_mode_l <= LM_NONE;
            ins_sh    <= '0;
            adr_sh    <= '0;
            ins_left  <= '0;
            adr_left  <= '0;
            sclk      <= 1'b0;
            cs_n      <= 1'b1;
            dq_out    <= '0;
            dq_oe     <= '0;
            busy      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        busy      <= 1'b1;
                        op_mode_l <= cfg.op_lines;
                        ad_mode_l <= cfg.ad_lines;
                        ins_sh    <= cfg.opcode;
                        adr_sh    <= ad_aligned;
                        ins_left  <= ins_beats;
                        adr_left  <= adr_beats;
                        lead_done <= 1'b0;
                        if (cfg.op_lines == LM_NONE && cfg.ad_lines == LM_NONE) begin
                            state <= ST_EMPTY;
                        end else begin
                            state <= ST_LEAD;
                        end
                    end
                end
                ST_EMPTY: begin
                    busy  <= 1'b0;
                    state <= ST_IDLE;
                end
                ST_LEAD: begin
                    if (!lead_done) begin
                        lead_done <= 1'b1;
                    end else begin
                        cs_n   <= 1'b0;
                        dq_out <= emit_dq;
                        dq_oe  <= emit_oe;
                        if (use_ins) begin
                            ins_sh   <= ins_sh << lanes_of(op_mode_l);
                            ins_left <= ins_left - 1'b1;
                        end else begin
                            adr_sh   <= adr_sh << lanes_of(ad_mode_l);
                            adr_left <= adr_left - 1'b1;
                        end
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (!sclk) begin
                        sclk <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        if (beats_left) begin
                            dq_out <= emit_dq;
                            dq_oe  <= emit_oe;
                            if (use_ins) begin
                                ins_sh   <= ins_sh << lanes_of(op_mode_l);
                                ins_left <= ins_left - 1'b1;
                            end else begin
                                adr_sh   <= adr_sh << lanes_of(ad_mode_l);
                                adr_left <= adr_left - 1'b1;
                            end
                        end else begin
                            cs_n   <= 1'b1;
                            dq_out <= '0;
                            dq_oe  <= '0;
                            state  <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    busy  <= 1'b0;
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r10_data_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> ($stable(dq_out) && $stable(dq_oe)));

    a_r11_no_drive_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (dq_oe == 4'b0000));

    a_r11_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'b0000) || (dq_oe == 4'b0001) || (dq_oe == 4'b0011) || (dq_oe == 4'b1111));

    a_r9_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_busy_falls_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> $fell(busy));

    a_r12_cs_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

endmodule

// File: rtl/qspi_cmd_seq.sv
// Module: top of the command phase sequencer. Joins the settings bank
// and the sequencer; the bank is locked by the sequencer's busy flag.
module qspi_cmd_seq
    import qcs_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INSTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_opcode,
    input  logic [1:0]        cfg_op_lines,
    input  logic [1:0]        cfg_ad_lines,
    input  logic [1:0]        cfg_ad_size,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              dual_flash,
    input  logic              mmap_mode,
    input  logic              start,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic              busy
);

    cmd_cfg_t          cfg_in;
    cmd_cfg_t          cfg_q;
    logic [ADDR_W-1:0] addr_q;

    // Pack the configuration inputs into the shared settings type.
    always_comb begin
        cfg_in.opcode   = cfg_opcode;
        cfg_in.op_lines = line_mode_e'(cfg_op_lines);
        cfg_in.ad_lines = line_mode_e'(cfg_ad_lines);
        cfg_in.ad_size  = cfg_ad_size;
    end

    qcs_cfg_bank #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .mmap_mode (mmap_mode),
        .cfg_we    (cfg_we),
        .cfg_in    (cfg_in),
        .addr_we   (addr_we),
        .addr_in   (addr_val),
        .cfg_q     (cfg_q),
        .addr_q    (addr_q)
    );

    qcs_seq #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dual_flash (dual_flash),
        .cfg        (cfg_q),
        .addr       (addr_q),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .busy       (busy)
    );

endmodule

// File: tb/qspi_cmd_seq_tb.sv
module qspi_cmd_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_opcode = '0;
    logic [1:0]  cfg_op_lines = '0;
    logic [1:0]  cfg_ad_lines = '0;
    logic [1:0]  cfg_ad_size = '0;
    logic        addr_we = 1'b0;
    logic [31:0] addr_val = '0;
    logic        dual_flash = 1'b0;
    logic        mmap_mode = 1'b0;
    logic        start = 1'b0;
    logic        sclk, cs_n, busy;
    logic [3:0]  dq_out, dq_oe;

    always #2 clk = ~clk;

    qspi_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opcode(cfg_opcode),
        .cfg_op_lines(cfg_op_lines), .cfg_ad_lines(cfg_ad_lines),
        .cfg_ad_size(cfg_ad_size), .addr_we(addr_we), .addr_val(addr_val),
        .dual_flash(dual_flash), .mmap_mode(mmap_mode), .start(start),
        .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the stored settings.
    logic [7:0]  m_op = '0;
    logic [1:0]  m_ol = '0;
    logic [1:0]  m_al = '0;
    logic [1:0]  m_as = '0;
    logic [31:0] m_addr = '0;

    logic [3:0] exp_dq [64];
    logic [3:0] exp_oe [64];
    int         exp_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lanes(input logic [1:0] m);
        return (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : (m == 2'b11) ? 4 : 0;
    endfunction

    // Expected beat list from the requirements (R2, R3, R4, R5, R8, R11).
    task automatic build_exp(input bit dual);
        int w;
        int nbits;
        logic [31:0] a;
        logic [3:0] v;
        exp_n = 0;
        w = lanes(m_ol);
        if (w > 0) begin
            for (int b = 0; b < 8 / w; b++) begin
                v = '0;
                for (int k = 0; k < w; k++) v[w-1-k] = m_op[7 - b*w - k];
                exp_dq[exp_n] = v;
                exp_oe[exp_n] = 4'((1 << w) - 1);
                exp_n++;
            end
        end
        w = lanes(m_al);
        a = dual ? {m_addr[31:1], 1'b0} : m_addr;
        nbits = (int'(m_as) + 1) * 8;
        if (w > 0) begin
            for (int b = 0; b < nbits / w; b++) begin
                v = '0;
                for (int k = 0; k < w; k++) v[w-1-k] = a[nbits - 1 - b*w - k];
                exp_dq[exp_n] = v;
                exp_oe[exp_n] = 4'((1 << w) - 1);
                exp_n++;
            end
        end
    endtask

    task automatic write_cfg(input logic [7:0] op, input logic [1:0] ol,
                             input logic [1:0] al, input logic [1:0] asz);
        @(negedge clk);
        cfg_opcode = op; cfg_op_lines = ol; cfg_ad_lines = al; cfg_ad_size = asz;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m_op = op; m_ol = ol; m_al = al; m_as = asz;
    endtask

    task automatic write_addr(input logic [31:0] v, input bit mm);
        @(negedge clk);
        addr_val = v; mmap_mode = mm; addr_we = 1'b1;
        @(negedge clk);
        addr_we = 1'b0; mmap_mode = 1'b0;
        if (!mm) m_addr = v;
    endtask

    // One command: start, observe, compare. inject=1 pokes settings,
    // address and start during the command (R6, R7, R9).
    task automatic run_txn(input string tag, input bit inject);
        int busy_cnt, cs_cnt, first_low, beats, bad, frame_bad, guard;
        logic prev_sclk;
        logic [3:0] got_dq, got_oe;
        build_exp(dual_flash);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cnt = 0; cs_cnt = 0; first_low = 0; beats = 0; bad = 0;
        frame_bad = 0; guard = 0; prev_sclk = 1'b0;
        got_dq = '0; got_oe = '0;
        while (busy === 1'b1 && guard < 1000) begin
            guard++;
            busy_cnt++;
            if (cs_n === 1'b0) begin
                cs_cnt++;
                if (first_low == 0) first_low = busy_cnt;
            end
            if (cs_n === 1'b1 && sclk !== 1'b0) frame_bad++;
            if (cs_n === 1'b1 && dq_oe !== 4'b0000) frame_bad++;
            if (sclk === 1'b1 && prev_sclk === 1'b0) begin
                if (beats < 64) begin
                    if (((dq_out & dq_oe) !== exp_dq[beats]) || (dq_oe !== exp_oe[beats])) begin
                        if (bad == 0) begin got_dq = dq_out & dq_oe; got_oe = dq_oe; end
                        bad++;
                    end
                end
                beats++;
            end
            prev_sclk = sclk;
            if (inject && busy_cnt == 3) begin
                cfg_we = 1'b1; cfg_opcode = 8'($urandom); cfg_op_lines = 2'($urandom);
                cfg_ad_lines = 2'($urandom); cfg_ad_size = 2'($urandom);
                addr_we = 1'b1; addr_val = $urandom; start = 1'b1;
            end else begin
                cfg_we = 1'b0; addr_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; addr_we = 1'b0; start = 1'b0;
        check(busy_cnt == ((exp_n == 0) ? 1 : 3 + 2*exp_n), "R9", {tag, " busy length"},
              busy_cnt, (exp_n == 0) ? 1 : 3 + 2*exp_n);
        check(cs_cnt == 2*exp_n, "R10", {tag, " cs low length"}, cs_cnt, 2*exp_n);
        check(first_low == ((exp_n == 0) ? 0 : 3), "R10", {tag, " cs lead"},
              first_low, (exp_n == 0) ? 0 : 3);
        check(frame_bad == 0, "R11", {tag, " idle framing"}, frame_bad, 0);
        check(beats == exp_n, tag, "beat count", beats, exp_n);
        check(bad == 0, tag, "beat data (dq,oe first bad)", {got_dq, got_oe}, 0);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n === 1'b1, "R1", "cs_n", cs_n, 1);
        check(sclk === 1'b0, "R1", "sclk", sclk, 0);
        check(dq_oe === 4'b0000, "R1", "dq_oe", dq_oe, 0);
        check(busy === 1'b0, "R1", "busy", busy, 0);

        // R5 single line, MSB first, 32-bit address
        write_cfg(8'hA5, 2'b01, 2'b01, 2'b11);
        write_addr(32'h1234_5679, 1'b0);
        run_txn("R5", 1'b0);
        // R2 four-line opcode, two-line 24-bit address
        write_cfg(8'h3C, 2'b11, 2'b10, 2'b10);
        run_txn("R2", 1'b0);
        // R3 two-line opcode, four-line 8-bit address
        write_cfg(8'hE7, 2'b10, 2'b11, 2'b00);
        run_txn("R3", 1'b0);
        // R4 no opcode, 16-bit address on four lines
        write_cfg(8'hFF, 2'b00, 2'b11, 2'b01);
        run_txn("R4", 1'b0);
        // R11 opcode only, single line
        write_cfg(8'h81, 2'b01, 2'b00, 2'b11);
        run_txn("R11", 1'b0);
        // R12 empty command
        write_cfg(8'h55, 2'b00, 2'b00, 2'b11);
        run_txn("R12", 1'b0);
        // R8 dual-device forces address even
        write_cfg(8'h0B, 2'b01, 2'b01, 2'b11);
        write_addr(32'h8000_00FF, 1'b0);
        dual_flash = 1'b1;
        run_txn("R8", 1'b0);
        dual_flash = 1'b0;
        // R7 address write blocked by memory-mapped mode
        write_addr(32'hDEAD_BEEF, 1'b1);
        run_txn("R7", 1'b0);
        // R9 start while busy ignored; R6 settings locked during command
        write_cfg(8'hC3, 2'b10, 2'b11, 2'b11);
        run_txn("R9", 1'b1);
        run_txn("R6", 1'b0);

        // Random commands
        for (int i = 0; i < 40; i++) begin
            write_cfg(8'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
            write_addr($urandom, ($urandom % 4) == 0);
            dual_flash = ($urandom % 3) == 0;
            run_txn("R5", ($urandom % 5) == 0);
        end
        dual_flash = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule